// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block is the digital back end of a two-channel supply supervisor. Two analog comparators, outside the block, report asynchronously whether the main digital supply and the charge-pump output are under their thresholds. The main supply threshold is 1.8 V and the charge-pump threshold is 2.7 V. Each report is brought into the block's clock domain through a short flop chain.

The main-supply channel controls an active-low reset output. Reset goes low as soon as the synchronized report shows the supply under its threshold. When the supply recovers, reset is held low for a long, programmable settling window so that an external crystal can settle. With the default count on a 32.768 kHz clock, this window is about 1.5 s. If the supply dips again inside the window, the window starts over from zero.

The charge-pump channel never touches reset. It only raises its own flag, and it offers its synchronized level as a source for interrupt logic elsewhere. Each channel has a sticky under-voltage flag. A status-read strobe clears both flags, except that a flag whose condition is still present on the read cycle stays set. A configuration bit that picks the comparator hysteresis is registered and presented back to the analog side.

Top module: `supply_reset_seq`

## Requirements
- R1: The output `rst_n_out` is 0 during and after `rst`, the flags `uv_main_flag` and `uv_cp_flag` are 0, and `hyst_out` is 0.
- R2: Both comparator inputs pass through SYNC_STAGES (default 2) flops. A change on `main_low_in` has no effect on `rst_n_out` for the first SYNC_STAGES-1 clock edges. `rst_n_out` goes to 0 right after the SYNC_STAGES-th edge and stays 0 as long as the synchronized level is high.
- R3: The flag `uv_main_flag` becomes 1 one clock edge after the synchronized main report goes high.
- R4: After `main_low_in` falls, `rst_n_out` goes to 1 exactly HOLD_CYCLES+SYNC_STAGES clock edges later. After `rst` is released with the supply good, `rst_n_out` goes to 1 exactly HOLD_CYCLES edges later.
- R5: If the synchronized main report goes high again before the hold window ends, the window restarts. After the report clears again, the full HOLD_CYCLES+SYNC_STAGES edges are needed before `rst_n_out` goes to 1.
- R6: When `cp_low_in` is high, `uv_cp_flag` becomes 1 SYNC_STAGES+1 edges later. `rst_n_out` is not affected at any time.
- R7: The output `cp_irq_src` equals `cp_low_in` delayed by SYNC_STAGES clock edges.
- R8: A cycle with `status_rd`=1 clears each flag on the next edge. A flag whose synchronized condition is still high on that cycle stays 1.
- R9: The output `hyst_out` takes the value of `hyst_sel` one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock (32.768 kHz in the target system) |
| rst | input | 1 | Synchronous active-high reset |
| main_low_in | input | 1 | Asynchronous main-supply under-threshold report |
| cp_low_in | input | 1 | Asynchronous charge-pump under-threshold report |
| hyst_sel | input | 1 | Hysteresis selection configuration bit |
| status_rd | input | 1 | Status read strobe; clears the sticky flags |
| rst_n_out | output | 1 | Active-low system reset |
| uv_main_flag | output | 1 | Sticky main-supply under-voltage flag |
| uv_cp_flag | output | 1 | Sticky charge-pump under-voltage flag |
| cp_irq_src | output | 1 | Synchronized charge-pump level offered to interrupt logic |
| hyst_out | output | 1 | Registered hysteresis selection sent to the comparator |

## Verification
The bench builds the block with HOLD_CYCLES=40 and SYNC_STAGES at its default of 2. With this short count, the exact release edge after power-up, the release edge after a recovery, and a dip that restarts the window can each be checked many times within a short run. The 49152-cycle default is not exercised cycle by cycle. The two-stage synchronizer is kept so that the latency counts checked for reset, flags and the interrupt source are the ones of the real configuration.

// File: rtl/supsup_pkg.sv
package supsup_pkg;

    // Synchronized monitor levels, one bit per comparator channel.
    typedef struct packed {
        logic cp_low;
        logic main_low;
    } mon_t;

    localparam int MON_CHANNELS = $bits(mon_t);

    // Phase of the reset hold window.
    typedef enum logic [1:0] {
        PH_HELD   = 2'd0,
        PH_COUNT  = 2'd1,
        PH_DONE   = 2'd2
    } hold_phase_t;

    // Sticky flag update: the live condition sets it, a read clears it.
    function automatic logic sticky_next(logic flag, logic cond, logic rd);
        return cond | (flag & ~rd);
    endfunction

endpackage

// File: rtl/supsup_sync.sv
module supsup_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain <= '0;
                end else if (STAGES == 1) begin
                    chain[0] <= d_async[b];
                end else begin
                    chain <= {chain[STAGES-2:0], d_async[b]};
                end
            end
            assign q_sync[b] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/supsup_hold_timer.sv
module supsup_hold_timer
    import supsup_pkg::*;
#(
    parameter int HOLD_CYCLES = 49152
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_low,
    output logic release_ok
);
    localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    hold_phase_t      phase;
    logic [CW-1:0]    cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_COUNT;
            cnt   <= '0;
        end else if (supply_low) begin
            phase <= PH_HELD;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_HELD: begin
                    // first good edge counts as the first of the window
                    if (LAST == '0) begin
                        phase <= PH_DONE;
                    end else begin
                        phase <= PH_COUNT;
                        cnt   <= CW'(1);
                    end
                end
                PH_COUNT: begin
                    if (cnt == LAST) begin
                        phase <= PH_DONE;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: phase <= PH_DONE;
            endcase
        end
    end

    assign release_ok = (phase == PH_DONE);
endmodule

// File: rtl/supsup_flags.sv
module supsup_flags
    import supsup_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  mon_t cond,
    input  logic rd,
    output mon_t flags
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags.main_low <= sticky_next(flags.main_low, cond.main_low, rd);
            flags.cp_low   <= sticky_next(flags.cp_low, cond.cp_low, rd);
        end
    end
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq
    import supsup_pkg::*;
#(
    parameter int HOLD_CYCLES = 49152,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic main_low_in,
    input  logic cp_low_in,
    input  logic hyst_sel,
    input  logic status_rd,
    output logic rst_n_out,
    output logic uv_main_flag,
    output logic uv_cp_flag,
    output logic cp_irq_src,
    output logic hyst_out
);
    mon_t raw_mon;
    mon_t sync_mon;
    mon_t flag_q;
    logic release_ok;
    logic hyst_q;

    assign raw_mon.main_low = main_low_in;
    assign raw_mon.cp_low   = cp_low_in;

    supsup_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (MON_CHANNELS)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (raw_mon),
        .q_sync  (sync_mon)
    );

    supsup_hold_timer #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .supply_low (sync_mon.main_low),
        .release_ok (release_ok)
    );

    supsup_flags u_flags (
        .clk   (clk),
        .rst   (rst),
        .cond  (sync_mon),
        .rd    (status_rd),
        .flags (flag_q)
    );

    always_ff @(posedge clk) begin
        if (rst) hyst_q <= 1'b0;
        else     hyst_q <= hyst_sel;
    end

    // reset drops in the same cycle the synchronized report goes high
    assign rst_n_out    = release_ok & ~sync_mon.main_low;
    assign uv_main_flag = flag_q.main_low;
    assign uv_cp_flag   = flag_q.cp_low;
    assign cp_irq_src   = sync_mon.cp_low;
    assign hyst_out     = hyst_q;
endmodule

// File: rtl/supply_reset_seq_chk.sv
module supply_reset_seq_chk #(
    parameter int HOLD_CYCLES = 49152
) (
    input logic clk,
    input logic rst,
    input logic main_s,
    input logic cp_s,
    input logic status_rd,
    input logic rst_n_out,
    input logic uv_main_flag,
    input logic uv_cp_flag,
    input logic cp_irq_src
);
    localparam int GW = $clog2(HOLD_CYCLES + 2) + 1;
    logic [GW-1:0] good_run;
    logic          seen_clk;

    always_ff @(posedge clk) begin
        seen_clk <= 1'b1;
        if (rst || main_s) good_run <= '0;
        else if (good_run < GW'(HOLD_CYCLES)) good_run <= good_run + GW'(1);
    end

    // R1: reset state
    a_r1_reset_state: assert property (@(posedge clk) rst |=> !rst_n_out && !uv_main_flag && !uv_cp_flag);

    // R2: reset low while the synchronized report is high
    a_r2_low_holds_reset: assert property (@(posedge clk) disable iff (rst) main_s |-> !rst_n_out);

    // R3: main flag set after a synchronized low report
    a_r3_main_flag_sets: assert property (@(posedge clk) disable iff (rst) main_s |=> uv_main_flag);

    // R4: release only after a full good window
    a_r4_release_window: assert property (@(posedge clk) disable iff (rst)
        (seen_clk && $rose(rst_n_out)) |-> (good_run >= GW'(HOLD_CYCLES)));

    // R6: charge-pump flag set after a synchronized low report
    a_r6_cp_flag_sets: assert property (@(posedge clk) disable iff (rst) cp_s |=> uv_cp_flag);

    // R7: interrupt source tracks the synchronized charge-pump level
    a_r7_irq_tracks: assert property (@(posedge clk) disable iff (rst) cp_irq_src == cp_s);

    // R8: a read with no live condition clears the flags
    a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
        (status_rd && !main_s && !cp_s) |=> (!uv_main_flag && !uv_cp_flag));
endmodule

bind supply_reset_seq supply_reset_seq_chk #(
    .HOLD_CYCLES (HOLD_CYCLES)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .main_s       (sync_mon.main_low),
    .cp_s         (sync_mon.cp_low),
    .status_rd    (status_rd),
    .rst_n_out    (rst_n_out),
    .uv_main_flag (uv_main_flag),
    .uv_cp_flag   (uv_cp_flag),
    .cp_irq_src   (cp_irq_src)
);

// File: tb/supply_reset_seq_bench.sv
`timescale 1ns/1ps
module supply_reset_seq_bench;
    localparam int T  = 40;
    localparam int SS = 2;

    logic clk = 1'b0;
    logic rst, main_low_in, cp_low_in, hyst_sel, status_rd;
    logic rst_n_out, uv_main_flag, uv_cp_flag, cp_irq_src, hyst_out;
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    supply_reset_seq #(.HOLD_CYCLES(T), .SYNC_STAGES(SS)) u_supply_reset_seq (
        .clk(clk), .rst(rst), .main_low_in(main_low_in), .cp_low_in(cp_low_in),
        .hyst_sel(hyst_sel), .status_rd(status_rd), .rst_n_out(rst_n_out),
        .uv_main_flag(uv_main_flag), .uv_cp_flag(uv_cp_flag),
        .cp_irq_src(cp_irq_src), .hyst_out(hyst_out)
    );

    task automatic chk(input logic act, input logic exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", what, act, exp);
        end
    endtask

    // advance n rising edges, then sit on the falling edge
    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    // expected release edge count after a recovery (R4)
    function automatic int rel_after_rec();
        return T + SS;
    endfunction

    task automatic read_status();
        status_rd = 1'b1;
        step(1);
        status_rd = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed_1234);
        rst = 1; main_low_in = 0; cp_low_in = 0; hyst_sel = 0; status_rd = 0;
        step(3);
        chk(rst_n_out, 1'b0, "R1 reset rst_n_out");
        chk(uv_main_flag, 1'b0, "R1 reset main flag");
        chk(uv_cp_flag, 1'b0, "R1 reset cp flag");
        chk(hyst_out, 1'b0, "R1 reset hyst_out");

        // power-up release, R4
        rst = 0;
        step(T - 1);
        chk(rst_n_out, 1'b0, "R4 power-up edge T-1");
        step(1);
        chk(rst_n_out, 1'b1, "R4 power-up edge T");

        // hysteresis, R9
        hyst_sel = 1'b1;
        chk(hyst_out, 1'b0, "R9 before edge");
        step(1);
        chk(hyst_out, 1'b1, "R9 after edge");
        hyst_sel = 1'b0;
        step(1);
        chk(hyst_out, 1'b0, "R9 back to 0");

        // main dip, R2 / R3
        main_low_in = 1'b1;
        step(SS - 1);
        chk(rst_n_out, 1'b1, "R2 not yet through sync");
        step(1);
        chk(rst_n_out, 1'b0, "R2 reset asserted");
        chk(uv_main_flag, 1'b0, "R3 flag one edge later");
        step(1);
        chk(uv_main_flag, 1'b1, "R3 main flag set");
        step(5);
        chk(rst_n_out, 1'b0, "R2 held while low");

        // R8 read while condition present keeps flag
        read_status();
        chk(uv_main_flag, 1'b1, "R8 flag kept while live");

        // recovery, R4
        main_low_in = 1'b0;
        step(rel_after_rec() - 1);
        chk(rst_n_out, 1'b0, "R4 recovery edge T+SS-1");
        step(1);
        chk(rst_n_out, 1'b1, "R4 recovery edge T+SS");
        chk(uv_main_flag, 1'b1, "R3 flag is sticky");
        read_status();
        chk(uv_main_flag, 1'b0, "R8 read clears main flag");

        // restart on dip during window, R5
        main_low_in = 1'b1;
        step(4);
        main_low_in = 1'b0;
        step(T / 2);
        chk(rst_n_out, 1'b0, "R5 mid window");
        main_low_in = 1'b1;
        step(3);
        main_low_in = 1'b0;
        step(rel_after_rec() - 1);
        chk(rst_n_out, 1'b0, "R5 restarted window edge T+SS-1");
        step(1);
        chk(rst_n_out, 1'b1, "R5 restarted window edge T+SS");
        read_status();

        // charge-pump directed, R6 / R7
        cp_low_in = 1'b1;
        step(SS - 1);
        chk(cp_irq_src, 1'b0, "R7 irq before sync");
        step(1);
        chk(cp_irq_src, 1'b1, "R7 irq after sync");
        chk(uv_cp_flag, 1'b0, "R6 cp flag one edge later");
        step(1);
        chk(uv_cp_flag, 1'b1, "R6 cp flag set");
        chk(rst_n_out, 1'b1, "R6 reset unaffected");
        cp_low_in = 1'b0;
        step(SS);
        chk(cp_irq_src, 1'b0, "R7 irq clears");
        chk(uv_cp_flag, 1'b1, "R6 cp flag sticky");
        read_status();
        chk(uv_cp_flag, 1'b0, "R8 read clears cp flag");
        chk(uv_main_flag, 1'b0, "R8 main flag stays clear");

        // random charge-pump pulses: reset never moves, R6 / R7
        for (int it = 0; it < 200; it++) begin
            logic lvl;
            int hold;
            lvl  = 1'($urandom_range(0, 1));
            hold = $urandom_range(SS + 1, SS + 6);
            cp_low_in = lvl;
            step(hold);
            chk(cp_irq_src, lvl, "R7 random irq level");
            chk(rst_n_out, 1'b1, "R6 random reset unaffected");
            if (lvl) chk(uv_cp_flag, 1'b1, "R6 random cp flag");
            if ($urandom_range(0, 3) == 0) begin
                read_status();
                chk(uv_cp_flag, lvl, "R8 random read");
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule